// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the word address for a synchronous memory that runs four-beat bursts. A burst begins when either of two active-low start strobes is sampled with the right enables. The processor strobe needs every chip enable to be active. The controller strobe ignores the master enable but yields to the processor strobe. On a start, the external address is captured. After that, each advance beat steps a two-bit burst count. The low address bits follow either an interleaved order or a linear order.

The order is chosen by a select input and is frozen when the burst starts. The upper address bits keep their captured value for the whole burst. The count wraps after four beats, so the burst returns to its starting offset. Storage, data paths and output-enable control sit outside this block. It only presents the current address.

Top module: `burst_addr_seq`

## Requirements
- R1: When `proc_strobe_n` is low, `en_master_n` is low, `en_hi` is high and `en_lo_n` is low at a rising edge, `cur_addr` equals the sampled `ext_addr` after that edge.
- R2: When `proc_strobe_n` is low while `en_master_n` is high, nothing is loaded, regardless of the controller strobe. `cur_addr` keeps its value.
- R3: When `ctrl_strobe_n` is low, `proc_strobe_n` is high, `en_hi` is high and `en_lo_n` is low, `ext_addr` is loaded whatever the value of `en_master_n`. If `proc_strobe_n` is also low, no controller start takes place.
- R4: On an edge that loads through the processor strobe, `adv_n` has no effect. `cur_addr` equals the new `ext_addr` with a count of zero.
- R5: When both strobes are high and `adv_n` is low, `cur_addr` moves to the next burst address. Any start on the same edge takes priority over the advance.
- R6: An advance also takes place when one or more bits of `byte_wr_n` are low (a write beat).
- R7: When `order_sel` is 1 at the start, beat k presents low bits = start offset XOR k.
- R8: When `order_sel` is 0 at the start, beat k presents low bits = (start offset + k) mod 4.
- R9: After the fourth advance, the low bits return to the start offset. Bits above bit 1 never change during a burst.
- R10: With no start and `adv_n` high, `cur_addr` holds.
- R11: A change of `order_sel` during a burst has no effect until the next start.
- R12: After reset, `cur_addr` is zero.
- R13: A controller-strobe cycle with `en_hi` low or `en_lo_n` high loads nothing. `cur_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External start address |
| proc_strobe_n | input | 1 | Processor start strobe, active low |
| ctrl_strobe_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_master_n | input | 1 | Master chip enable, active low, gates the processor strobe only |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order, sampled at start |
| byte_wr_n | input | BYTES | Byte-write strobes, active low |
| cur_addr | output | ADDR_W | Current internal address |

## Verification
A start and an advance can fall on the same edge when a strobe is low while `adv_n` is low. The bench provokes this in two ways. First, it holds `adv_n` low across a processor-strobe load. Second, it pulses the controller strobe in the middle of a running burst with `adv_n` low. In both cases the bench expects the freshly sampled `ext_addr` with no increment applied. The master-enable gating is judged the same way. The processor and controller strobes are driven low together with the master enable off, and `cur_addr` must not move.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_PROC = 2'd1,
    START_CTRL = 2'd2
  } start_kind_t;
endpackage

// File: rtl/bas_start_decode.sv
module bas_start_decode
  import burst_addr_seq_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              en_master_n,
  input  logic              en_hi,
  input  logic              en_lo_n,
  input  logic [BYTES-1:0]  byte_wr_n,
  output start_kind_t       start_kind,
  output logic              step
);
  // Named internal events, kept visible for the assertions
  logic sec_ok;
  logic proc_go;
  logic ctrl_go;
  logic strobes_idle;
  logic read_beat;
  logic write_beat;

  assign sec_ok       = en_hi & ~en_lo_n;
  assign proc_go      = ~proc_strobe_n & ~en_master_n & sec_ok;
  assign ctrl_go      = ~ctrl_strobe_n & proc_strobe_n & sec_ok;
  assign strobes_idle = proc_strobe_n & ctrl_strobe_n;
  assign read_beat    = strobes_idle & ~adv_n & (&byte_wr_n);
  assign write_beat   = strobes_idle & ~adv_n & ~(&byte_wr_n);
  assign step         = read_beat | write_beat;

  always_comb begin
    if (proc_go)      start_kind = START_PROC;
    else if (ctrl_go) start_kind = START_CTRL;
    else              start_kind = START_NONE;
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({proc_go, ctrl_go, step})) else $error("start/advance overlap"); // R5
  AST_BLOCKED_PROC: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && en_master_n) |-> (start_kind == START_NONE && !step))
    else $error("blocked processor strobe acted"); // R2
endmodule

// File: rtl/bas_burst_counter.sv
module bas_burst_counter #(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [BB-1:0] start_in,
  input  logic          order_in,
  output logic [BB-1:0] offset
);
  logic [BB-1:0] start_q;
  logic [BB-1:0] cnt_q;
  logic          inter_q;

  function automatic logic [BB-1:0] beat_offset(input logic [BB-1:0] s,
                                                input logic [BB-1:0] k,
                                                input logic          inter);
    if (inter) return s ^ k;
    return BB'(s + k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      inter_q <= 1'b0;
    end else if (load) begin
      start_q <= start_in;
      cnt_q   <= '0;
      inter_q <= order_in;
    end else if (step) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign offset = beat_offset(start_q, cnt_q, inter_q);

  AST_LOAD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> offset == $past(start_in)) else $error("offset not loaded"); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !inter_q) |=> offset == BB'($past(offset) + 1'b1))
    else $error("linear step wrong"); // R8
  AST_INTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && inter_q) |=> offset != $past(offset))
    else $error("interleaved step stalled"); // R7
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 4,
  parameter int BB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              en_master_n,
  input  logic              en_hi,
  input  logic              en_lo_n,
  input  logic              order_sel,
  input  logic [BYTES-1:0]  byte_wr_n,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int UPPER_W = ADDR_W - BB;

  start_kind_t        start_kind;
  logic               step;
  logic               load;
  logic [BB-1:0]      offset;
  logic [UPPER_W-1:0] upper_q;

  bas_start_decode #(.BYTES(BYTES)) u_decode (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .en_master_n   (en_master_n),
    .en_hi         (en_hi),
    .en_lo_n       (en_lo_n),
    .byte_wr_n     (byte_wr_n),
    .start_kind    (start_kind),
    .step          (step)
  );

  assign load = (start_kind != START_NONE);

  bas_burst_counter #(.BB(BB)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .start_in (ext_addr[BB-1:0]),
    .order_in (order_sel),
    .offset   (offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    upper_q <= '0;
    else if (load) upper_q <= ext_addr[ADDR_W-1:BB];
  end

  assign cur_addr = {upper_q, offset};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_addr == $past(ext_addr)) else $error("address not captured"); // R1
  AST_MASTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && en_master_n) |=> $stable(cur_addr)) else $error("master enable ignored"); // R2
  AST_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_kind == START_PROC && !adv_n) |=> cur_addr == $past(ext_addr))
    else $error("advance acted on start edge"); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe_n && ctrl_strobe_n && adv_n) |=> $stable(cur_addr)) else $error("idle drift"); // R10
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(cur_addr[ADDR_W-1:BB])) else $error("upper bits moved"); // R9
  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe_n && proc_strobe_n && (!en_hi || en_lo_n)) |=> $stable(cur_addr))
    else $error("deselected controller strobe loaded"); // R13
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int  AW = 18;
  localparam int  NB = 4;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          proc_strobe_n = 1'b1;
  logic          ctrl_strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          en_master_n = 1'b0;
  logic          en_hi = 1'b1;
  logic          en_lo_n = 1'b0;
  logic          order_sel = 1'b1;
  logic [NB-1:0] byte_wr_n = '1;
  logic [AW-1:0] cur_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BYTES(NB), .BB(2)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .en_master_n(en_master_n), .en_hi(en_hi),
    .en_lo_n(en_lo_n), .order_sel(order_sel), .byte_wr_n(byte_wr_n),
    .cur_addr(cur_addr)
  );

  function automatic logic [AW-1:0] model(input logic [AW-1:0] base, input int k,
                                          input bit inter);
    int s;
    int lo;
    s = int'(base[1:0]);
    if (inter) lo = s ^ (k % 4);
    else       lo = (s + k) % 4;
    return {base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (cur_addr !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, cur_addr, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
    en_master_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0; byte_wr_n = '1;
  endtask

  task automatic proc_start(input logic [AW-1:0] a, input bit inter);
    ext_addr = a; order_sel = inter; proc_strobe_n = 1'b0;
    tick();
    idle();
  endtask

  task automatic t_reset();
    check("R12", '0);
  endtask

  task automatic t_proc_load();
    proc_start(18'h2A5B6, 1'b1);
    check("R1", 18'h2A5B6);
    ext_addr = 18'h11113; proc_strobe_n = 1'b0; adv_n = 1'b0;
    tick(); idle();
    check("R4", 18'h11113);
  endtask

  task automatic t_interleave();
    logic [AW-1:0] b = 18'h3C0F2;
    proc_start(b, 1'b1);
    for (int k = 1; k <= 4; k++) begin
      adv_n = 1'b0; tick(); adv_n = 1'b1;
      if (k < 4) check("R7", model(b, k, 1'b1));
      else       check("R9", b);
    end
  endtask

  task automatic t_linear();
    logic [AW-1:0] b = 18'h01237;
    proc_start(b, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      adv_n = 1'b0; tick(); adv_n = 1'b1;
      if (k < 4) check("R8", model(b, k, 1'b0));
      else       check("R9", b);
    end
  endtask

  task automatic t_master_block();
    logic [AW-1:0] b = 18'h0AAA0;
    proc_start(b, 1'b1);
    ext_addr = 18'h15555; en_master_n = 1'b1; proc_strobe_n = 1'b0; adv_n = 1'b0;
    tick();
    check("R2", b);
    ctrl_strobe_n = 1'b0;
    tick(); idle();
    check("R3", b);
  endtask

  task automatic t_ctrl_start();
    en_master_n = 1'b1; ext_addr = 18'h2F0E1; order_sel = 1'b0; ctrl_strobe_n = 1'b0;
    tick(); idle();
    check("R3", 18'h2F0E1);
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    check("R8", model(18'h2F0E1, 1, 1'b0));
  endtask

  task automatic t_ctrl_deselect();
    logic [AW-1:0] b = 18'h00042;
    proc_start(b, 1'b1);
    ext_addr = 18'h3FFFF; en_hi = 1'b0; ctrl_strobe_n = 1'b0;
    tick();
    check("R13", b);
    en_hi = 1'b1; en_lo_n = 1'b1;
    tick(); idle();
    check("R13", b);
  endtask

  task automatic t_write_beat();
    logic [AW-1:0] b = 18'h12340;
    proc_start(b, 1'b0);
    byte_wr_n = 4'b1110; adv_n = 1'b0; tick(); idle();
    check("R6", model(b, 1, 1'b0));
    byte_wr_n = 4'b0000; adv_n = 1'b0; tick(); idle();
    check("R6", model(b, 2, 1'b0));
    adv_n = 1'b0; tick(); idle();
    check("R5", model(b, 3, 1'b0));
  endtask

  task automatic t_hold();
    logic [AW-1:0] b = 18'h2BEE5;
    proc_start(b, 1'b1);
    adv_n = 1'b0; tick(); idle();
    for (int i = 0; i < 3; i++) begin
      ext_addr = 18'h3A5A5 ^ AW'(i); byte_wr_n = 4'b0101;
      tick();
      check("R10", model(b, 1, 1'b1));
    end
    idle();
  endtask

  task automatic t_mode_latch();
    logic [AW-1:0] b = 18'h0F001;
    proc_start(b, 1'b1);
    order_sel = 1'b0;
    adv_n = 1'b0; tick(); idle();
    check("R11", model(b, 1, 1'b1));
    adv_n = 1'b0; tick(); idle();
    check("R11", model(b, 2, 1'b1));
  endtask

  task automatic t_start_beats_adv();
    logic [AW-1:0] b = 18'h20002;
    proc_start(b, 1'b0);
    adv_n = 1'b0; tick();
    ext_addr = 18'h1C7D3; ctrl_strobe_n = 1'b0; order_sel = 1'b1;
    tick(); idle();
    check("R5", 18'h1C7D3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_proc_load();
    t_interleave();
    t_linear();
    t_master_block();
    t_ctrl_start();
    t_ctrl_deselect();
    t_write_beat();
    t_hold();
    t_mode_latch();
    t_start_beats_adv();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run();
  end
endmodule